// File: doc/BRIEF.md
# Receive Frame Sync Hunter

This block watches a serial stream of recovered receive bits for a programmable 16-bit frame synchronisation word. Each received bit arrives on `bit_i` and is qualified by a single-cycle bit-clock enable. After a start command in receive mode, the block slides a 16-bit window over the incoming bits. It reports a match only when every bit of the window equals the loaded word.

On a match the block pulses a sync indication. It then collects the next 24 bits of the frame head: the first control byte, the second control byte, and a check byte. That check byte packs a 4-bit code for each control byte, the upper nibble for the first byte and the lower nibble for the second. Bytes arrive most significant bit first. Once the last head bit is in, a done flag rises and the block waits idle for the next start command. Bit timing recovery and correction of the head bytes are done elsewhere.

A controller loads the two pattern bytes first and then issues the start command. Best practice is to issue it about twelve bit periods after any clock or level acquisition, so that early noisy bits do not cause false matches.

Top module: `frame_sync_hunter`

## Requirements
- R1: After reset `sync_o` and `done_o` are 0 and `ctrl_a_o`, `ctrl_b_o` and `fec_o` are 0.
- R2: The search word is `{pat_hi_i, pat_lo_i}`, latched on an accepted start; `pat_hi_i` bit 7 is compared with the earliest of the 16 window bits. Changing the pattern inputs after the start has no effect on the search.
- R3: A match requires all 16 window bits to equal the search word; a window differing in any single bit gives no sync.
- R4: Only bits received after the accepted start enter the window; no match is reported before 16 such bits have arrived.
- R5: `sync_o` is high for exactly one clock cycle, in the cycle after the clock edge that sampled the bit completing the match.
- R6: The 24 bits after the match are shifted in MSB first: the first 8 appear on `ctrl_a_o`, the next 8 on `ctrl_b_o`, the last 8 on `fec_o`. `done_o` rises after the edge that samples the 24th bit and stays high until the next accepted start.
- R7: After capture completes, the block is idle: further bits, including a new copy of the search word, produce no sync and leave the head outputs and `done_o` unchanged.
- R8: An accepted start during search or capture restarts the search: `done_o` and the head outputs clear to 0 and the window is emptied.
- R9: With `rx_mode_i` low, start commands are ignored; dropping `rx_mode_i` during search or capture returns the block to idle without sync or done.
- R10: Cycles with `bit_en_i` low do not shift any bit, whatever the value of `bit_i`.
- R11: A bit presented in the same cycle as an accepted start is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_mode_i | input | 1 | Receive mode; search and capture run only while high |
| bit_en_i | input | 1 | Bit-clock enable, one cycle per received bit |
| bit_i | input | 1 | Received serial bit |
| pat_hi_i | input | 8 | First-received byte of the search word |
| pat_lo_i | input | 8 | Second-received byte of the search word |
| start_i | input | 1 | Start (or restart) the search |
| sync_o | output | 1 | One-cycle pulse on a full match |
| ctrl_a_o | output | 8 | First captured control byte |
| ctrl_b_o | output | 8 | Second captured control byte |
| fec_o | output | 8 | Captured check byte (upper nibble for byte A, lower for B) |
| done_o | output | 1 | Head capture complete |

## Verification
Directed frames carry a bit-sync preamble of alternating bit pairs ahead of a fixed word. These show that the preamble never aliases into a match and that the head bytes land in the right fields. Near misses check that single-bit differences are rejected. Partial words split across a start check that stale window content is discarded. Randomised frames vary the search word, the noise length, the gaps between bit enables, restarts during capture, and drops of receive mode. A bench model follows every bit, so a sync found too early, too late or never shows up as a mismatch on the bit where it occurs.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_GRAB = 2'd2
  } fsh_state_e;
endpackage

// File: rtl/fsh_window.sv
module fsh_window #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic [W-1:0] pattern_i,
  output logic         hit_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  win_q;
  logic [W-1:0]  win_d;
  logic [CW-1:0] fill_q;

  assign win_d = {win_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      win_q <= win_d;
      if (fill_q != CW'(W)) fill_q <= fill_q + 1'b1;
    end
  end

  // match is judged on the window including the bit now arriving
  assign hit_o = shift_i && !clr_i && (fill_q >= CW'(W - 1)) && (win_d == pattern_i);

  // R4
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CW'(W));

  // R4
  hit_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> fill_q == CW'(W));
endmodule

// File: rtl/fsh_capture.sv
module fsh_capture #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] head_o,
  output logic         last_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  head_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i) begin
      head_q <= {head_q[W-2:0], bit_i};
      cnt_q  <= (cnt_q == CW'(W - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign head_o = head_q;
  assign last_o = shift_i && !clr_i && (cnt_q == CW'(W - 1));

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W - 1));

  // R6
  last_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> cnt_q == '0);
endmodule

// File: rtl/frame_sync_hunter.sv
module frame_sync_hunter
  import fsh_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_mode_i,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic [BYTE_W-1:0] pat_hi_i,
  input  logic [BYTE_W-1:0] pat_lo_i,
  input  logic              start_i,
  output logic              sync_o,
  output logic [BYTE_W-1:0] ctrl_a_o,
  output logic [BYTE_W-1:0] ctrl_b_o,
  output logic [BYTE_W-1:0] fec_o,
  output logic              done_o
);
  localparam int SYNC_W = 2 * BYTE_W;
  localparam int HEAD_W = 3 * BYTE_W;

  fsh_state_e        state_q, state_d;
  logic [SYNC_W-1:0] pat_q;
  logic              start_ok;
  logic              hunt_shift, grab_shift;
  logic              hit, last;
  logic              sync_q, done_q;
  logic [HEAD_W-1:0] head;

  assign start_ok   = start_i && rx_mode_i;
  // a start in the same cycle wins over the bit (R11)
  assign hunt_shift = bit_en_i && rx_mode_i && !start_i && (state_q == ST_HUNT);
  assign grab_shift = bit_en_i && rx_mode_i && !start_i && (state_q == ST_GRAB);

  fsh_window #(.W(SYNC_W)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .shift_i   (hunt_shift),
    .bit_i     (bit_i),
    .pattern_i (pat_q),
    .hit_o     (hit)
  );

  fsh_capture #(.W(HEAD_W)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_ok),
    .shift_i (grab_shift),
    .bit_i   (bit_i),
    .head_o  (head),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    if (!rx_mode_i)                     state_d = ST_IDLE;
    else if (start_i)                   state_d = ST_HUNT;
    else if (state_q == ST_HUNT && hit) state_d = ST_GRAB;
    else if (state_q == ST_GRAB && last) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pat_q   <= '0;
      sync_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= hit && (state_q == ST_HUNT);
      if (start_ok) begin
        pat_q  <= {pat_hi_i, pat_lo_i};
        done_q <= 1'b0;
      end else if (last) begin
        done_q <= 1'b1;
      end
    end
  end

  assign sync_o   = sync_q;
  assign done_o   = done_q;
  assign ctrl_a_o = head[HEAD_W-1 -: BYTE_W];
  assign ctrl_b_o = head[HEAD_W-BYTE_W-1 -: BYTE_W];
  assign fec_o    = head[BYTE_W-1:0];

  // R5
  sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  // R9
  sync_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(rx_mode_i));

  // R6
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_GRAB && bit_en_i));

  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> (!done_o && !sync_o && state_q == ST_HUNT));

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !sync_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> $stable(head));
endmodule

// File: tb/test_frame_sync_hunter.sv
`timescale 1ns/1ps
module test_frame_sync_hunter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_mode_i = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] pat_hi_i = '0;
  logic [7:0] pat_lo_i = '0;
  logic       start_i = 1'b0;
  logic       sync_o, done_o;
  logic [7:0] ctrl_a_o, ctrl_b_o, fec_o;

  always #2 clk_i = ~clk_i;

  frame_sync_hunter i_frame_sync_hunter (
    .clk_i, .rst_ni, .rx_mode_i, .bit_en_i, .bit_i, .pat_hi_i, .pat_lo_i,
    .start_i, .sync_o, .ctrl_a_o, .ctrl_b_o, .fec_o, .done_o
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model, built from the requirements
  int          m_st = 0;   // 0 idle, 1 search, 2 capture
  bit          m_rx = 0;
  logic [15:0] m_win = '0, m_pat = '0;
  int          m_fill = 0;
  logic [23:0] m_head = '0;
  int          m_cnt = 0;
  bit          m_done = 0, m_sync = 0;
  int          n_sync_seen = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 sync"}, 32'(sync_o), 32'(m_sync));
    chk({tag, " R6 done"}, 32'(done_o), 32'(m_done));
    chk({tag, " R6 ctrl_a"}, 32'(ctrl_a_o), 32'(m_head[23:16]));
    chk({tag, " R6 ctrl_b"}, 32'(ctrl_b_o), 32'(m_head[15:8]));
    chk({tag, " R6 fec"}, 32'(fec_o), 32'(m_head[7:0]));
    if (sync_o) n_sync_seen++;
  endtask

  function automatic void model_bit(input logic b);
    m_sync = 0;
    if (!m_rx) return;
    if (m_st == 1) begin
      m_win = {m_win[14:0], b};
      if (m_fill < 16) m_fill++;
      if (m_fill == 16 && m_win == m_pat) begin
        m_sync = 1; m_st = 2; m_cnt = 0;
      end
    end else if (m_st == 2) begin
      m_head = {m_head[22:0], b};
      m_cnt++;
      if (m_cnt == 24) begin m_done = 1; m_st = 0; end
    end
  endfunction

  // R10: gap cycles with bit_en low and a noisy bit_i
  task automatic gap(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      bit_i = 1'($urandom);
      @(posedge clk_i); @(negedge clk_i);
      m_sync = 0;
      check_all({tag, " R10 gap"});
    end
  endtask

  task automatic apply_bit(input logic b, input int gap_n, input string tag);
    bit_en_i = 1'b1; bit_i = b;
    @(posedge clk_i); @(negedge clk_i);
    bit_en_i = 1'b0;
    model_bit(b);
    check_all(tag);
    gap(gap_n, tag);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap_n, input string tag);
    for (int i = 7; i >= 0; i--) apply_bit(v[i], gap_n, tag);
  endtask

  task automatic do_start(input logic [15:0] p, input bit with_bit, input string tag);
    pat_hi_i = p[15:8]; pat_lo_i = p[7:0];
    start_i = 1'b1;
    if (with_bit) begin bit_en_i = 1'b1; bit_i = 1'($urandom); end
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0; bit_en_i = 1'b0;
    m_sync = 0;
    if (m_rx) begin
      m_st = 1; m_win = '0; m_fill = 0; m_head = '0; m_cnt = 0; m_done = 0; m_pat = p;
    end
    check_all({tag, " R8 start"});
    // R2: pattern inputs move after the start
    pat_hi_i = 8'($urandom); pat_lo_i = 8'($urandom);
  endtask

  task automatic set_rx(input bit v);
    rx_mode_i = v; m_rx = v;
    if (!v) m_st = 0;
    @(posedge clk_i); @(negedge clk_i);
    m_sync = 0;
    check_all("R9 rx");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    chk("R1 sync", 32'(sync_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after release");

    // R9: start ignored outside receive mode, then pattern present
    do_start(16'hE4B7, 0, "R9");
    s0 = n_sync_seen;
    send_byte(8'hE4, 0, "R9"); send_byte(8'hB7, 0, "R9");
    chk("R9 no sync without rx", 32'(n_sync_seen - s0), 0);

    // directed frame with base-station preamble
    set_rx(1);
    do_start(16'hE4B7, 0, "R2");
    send_byte(8'h00, 1, "R3"); send_byte(8'hCC, 0, "R3"); send_byte(8'hCC, 2, "R3");
    s0 = n_sync_seen;
    send_byte(8'hE4, 0, "R2"); send_byte(8'hB7, 1, "R2");
    chk("R2 one sync on word", 32'(n_sync_seen - s0), 1);
    send_byte(8'hA5, 0, "R6"); send_byte(8'h3C, 1, "R6"); send_byte(8'h96, 0, "R6");
    chk("R6 done set", 32'(done_o), 1);
    chk("R6 ctrl_a value", 32'(ctrl_a_o), 32'h00A5);
    chk("R6 ctrl_b value", 32'(ctrl_b_o), 32'h003C);
    chk("R6 fec value", 32'(fec_o), 32'h0096);

    // R7: idle after capture
    s0 = n_sync_seen;
    send_byte(8'hE4, 0, "R7"); send_byte(8'hB7, 0, "R7"); send_byte(8'h11, 0, "R7");
    chk("R7 no sync in idle", 32'(n_sync_seen - s0), 0);
    chk("R7 ctrl_a held", 32'(ctrl_a_o), 32'h00A5);

    // R3: single-bit near misses, mobile preamble
    do_start(16'hE4B7, 0, "R3");
    send_byte(8'h33, 0, "R3"); send_byte(8'h33, 0, "R3");
    s0 = n_sync_seen;
    send_byte(8'hE4, 0, "R3"); send_byte(8'hB6, 0, "R3");
    send_byte(8'h00, 0, "R3");
    send_byte(8'h64, 0, "R3"); send_byte(8'hB7, 0, "R3");
    chk("R3 near miss rejected", 32'(n_sync_seen - s0), 0);

    // R4: word split across a start
    do_start(16'hE4B7, 0, "R4");
    send_byte(8'hE4, 0, "R4");
    do_start(16'hE4B7, 0, "R4");
    s0 = n_sync_seen;
    send_byte(8'hB7, 0, "R4");
    chk("R4 stale bits dropped", 32'(n_sync_seen - s0), 0);

    // R11: start with a bit in the same cycle, then a clean word
    do_start(16'h0001, 1, "R11");
    s0 = n_sync_seen;
    send_byte(8'h00, 0, "R11"); send_byte(8'h01, 0, "R11");
    chk("R11 word after start", 32'(n_sync_seen - s0), 1);

    // R8: restart in the middle of capture
    send_byte(8'hFF, 0, "R8");
    do_start(16'h1234, 0, "R8");
    chk("R8 head cleared", 32'(ctrl_a_o), 0);

    // R9: receive mode drops during capture
    send_byte(8'h12, 0, "R9"); send_byte(8'h34, 0, "R9"); send_byte(8'h77, 0, "R9");
    set_rx(0);
    send_byte(8'h55, 0, "R9"); send_byte(8'h55, 0, "R9");
    chk("R9 no done after drop", 32'(done_o), 0);
    set_rx(1);

    // randomised frames
    for (int it = 0; it < 60; it++) begin
      logic [15:0] p;
      int gn;
      p  = 16'($urandom);
      gn = int'($urandom_range(0, 2));
      do_start(p, ($urandom_range(0, 5) == 0), "R3 rnd");
      for (int k = 0; k < int'($urandom_range(0, 30)); k++)
        apply_bit(1'($urandom), gn, "R4 rnd");
      if ($urandom_range(0, 1) == 1) send_byte(8'hCC, gn, "R3 rnd");
      send_byte(p[15:8], gn, "R5 rnd"); send_byte(p[7:0], gn, "R5 rnd");
      if ($urandom_range(0, 7) == 0) do_start(p, 0, "R8 rnd");
      if ($urandom_range(0, 9) == 0) begin set_rx(0); set_rx(1); end
      for (int k = 0; k < 3; k++) send_byte(8'($urandom), gn, "R6 rnd");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule